// File: doc/BRIEF.md
# DDS Tuning Word Serial Loader

This block feeds a direct digital synthesizer with a new 40-bit tuning/control word once per audio sample period, so the synthesizer can be frequency modulated on a fixed time grid. A single-cycle sample tick starts each period. On the tick the block raises the synthesizer's commit line, which latches the word shifted during the previous period. It also issues a one-cycle start pulse to an external converter. When that converter reports completion, the block lowers the commit line and clocks the 40-bit word out serially. It then leaves the commit line low until the following tick.

The serial link uses clock polarity 0 and phase 0, and its clock is divided down from the system clock. The commit line also frames the transfer in the same way a chip select would. Its rising edge is held back on purpose from the end of the shift to the next tick. As a result, frequency changes always land exactly on sample boundaries. A tick that arrives while a shift is still running is reported as an overrun and is otherwise dropped.

Top module: `dds_word_loader`

## Requirements
- R1: Once a conversion has been started, a completion pulse with `word_vld_i` high starts a transfer of exactly 40 bits, `word_i[39]` first down to `word_i[0]`. This sends the control byte `[39:32]` first, followed by tuning bits 31..24, 23..16, 15..8 and 7..0.
- R2: The word is captured when the transfer starts, and changes on `word_i` during the shift do not alter the transmitted bits.
- R3: `sclk_o` is low whenever no transfer runs. `mosi_o` changes only while `sclk_o` is low. Every high phase of `sclk_o` lasts `SCLK_HALF` system cycles.
- R4: `latch_o` falls and `busy_o` rises in the cycle after the completion pulse is sampled. `busy_o` stays high for exactly 2*40*`SCLK_HALF` cycles. `latch_o` stays low through the shift and afterwards until the next tick.
- R5: A tick sampled while no shift runs drives `latch_o` high in the next cycle.
- R6: A tick sampled while no shift runs produces a one-cycle `adc_start_o` pulse in the next cycle.
- R7: A completion pulse is ignored when no conversion is pending. A completion pulse with `word_vld_i` low ends the wait with no transfer, and `latch_o` stays high.
- R8: A tick sampled during a shift, including the cycle of its final falling clock edge, gives a one-cycle `overrun_o` pulse and no `latch_o` rise or `adc_start_o`. The shift completes intact.
- R9: When a tick and a completion pulse are sampled in the same cycle while a conversion is pending, the tick wins. A new `adc_start_o` pulse is issued and no transfer starts.
- R10: After reset `latch_o` is high, and `sclk_o`, `mosi_o`, `busy_o`, `adc_start_o` and `overrun_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Single-cycle sample tick |
| adc_done_i | input | 1 | Single-cycle conversion-complete pulse |
| word_i | input | WORD_W | Tuning/control word, control byte in the top 8 bits |
| word_vld_i | input | 1 | `word_i` holds a word to send |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data, MSB first |
| latch_o | output | 1 | Commit line; low frames a transfer, rising edge commits |
| adc_start_o | output | 1 | One-cycle converter start pulse |
| busy_o | output | 1 | Shift in progress |
| overrun_o | output | 1 | One-cycle pulse: tick arrived during a shift |

## Verification
The sample tick can fall in the same cycle as the final falling clock edge of a shift. It can also fall in the same cycle as a converter completion pulse. The bench places a tick at every cycle offset through a transfer, including that final edge and the cycle just after it. For each offset it expects an overrun with the commit line held low, or, once the shift is over, a normal commit rise with a converter start. It also drives tick and completion together and expects the start pulse with no transfer, then a clean transfer on the next completion.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_HOLD  = 2'd3
  } ldr_state_t;
endpackage

// File: rtl/dds_sclk_gen.sv
module dds_sclk_gen #(
  parameter int SCLK_HALF = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic fall_evt
);
  localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(SCLK_HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // high phase ends on this edge: data may advance
  assign fall_evt = run && sclk && (cnt == LAST);
endmodule

// File: rtl/dds_word_shifter.sv
module dds_word_shifter #(
  parameter int WORD_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              adv,
  output logic              bit_out
);
  logic [WORD_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (load) begin
      hold_q <= word_in;
    end else if (adv) begin
      hold_q <= {hold_q[WORD_W-2:0], 1'b0};
    end
  end

  assign bit_out = hold_q[WORD_W-1];
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
  import dds_ldr_pkg::*;
#(
  parameter int WORD_W    = 40,
  parameter int SCLK_HALF = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              adc_done_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              latch_o,
  output logic              adc_start_o,
  output logic              busy_o,
  output logic              overrun_o
);
  localparam int BW = $clog2(WORD_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

  ldr_state_t     st;
  logic [BW-1:0]  bit_idx;
  logic           fall_evt;
  logic           start_shift;
  logic           shifting;

  assign shifting    = (st == ST_SHIFT);
  assign start_shift = (st == ST_WAIT) && !tick_i && adc_done_i && word_vld_i;

  dds_sclk_gen #(.SCLK_HALF(SCLK_HALF)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .run      (shifting),
    .sclk     (sclk_o),
    .fall_evt (fall_evt)
  );

  dds_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (start_shift),
    .word_in (word_i),
    .adv     (fall_evt),
    .bit_out (mosi_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      latch_o     <= 1'b1;
      adc_start_o <= 1'b0;
      overrun_o   <= 1'b0;
      busy_o      <= 1'b0;
      bit_idx     <= '0;
    end else begin
      adc_start_o <= 1'b0;
      overrun_o   <= 1'b0;
      case (st)
        ST_SHIFT: begin
          if (tick_i) overrun_o <= 1'b1;
          if (fall_evt) begin
            if (bit_idx == LAST_BIT) begin
              st     <= ST_HOLD;
              busy_o <= 1'b0;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        default: begin
          if (tick_i) begin
            latch_o     <= 1'b1;
            adc_start_o <= 1'b1;
            st          <= ST_WAIT;
          end else if (st == ST_WAIT && adc_done_i) begin
            if (word_vld_i) begin
              st      <= ST_SHIFT;
              latch_o <= 1'b0;
              busy_o  <= 1'b1;
              bit_idx <= '0;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dds_word_loader_chk.sv
module dds_word_loader_chk (
  input logic clk,
  input logic rst,
  input logic tick_i,
  input logic sclk_o,
  input logic mosi_o,
  input logic latch_o,
  input logic adc_start_o,
  input logic busy_o,
  input logic overrun_o
);
  AST_LATCH_LOW_IN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !latch_o); // R4

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !sclk_o); // R3

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R3

  AST_LATCH_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_o) |-> $past(tick_i)); // R5

  AST_START_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
    adc_start_o |-> ($past(tick_i) && !$past(busy_o))); // R6

  AST_OVERRUN_CLEAN: assert property (@(posedge clk) disable iff (rst)
    overrun_o |-> ($past(busy_o) && !latch_o && !adc_start_o)); // R8
endmodule

bind dds_word_loader dds_word_loader_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick_i      (tick_i),
  .sclk_o      (sclk_o),
  .mosi_o      (mosi_o),
  .latch_o     (latch_o),
  .adc_start_o (adc_start_o),
  .busy_o      (busy_o),
  .overrun_o   (overrun_o)
);

// File: tb/sim_dds_word_loader.sv
`timescale 1ns/1ps
module sim_dds_word_loader;
  localparam int W    = 40;
  localparam int HALF = 2;
  localparam int XLEN = 2 * W * HALF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0, adc_done_i = 1'b0, word_vld_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic sclk_o, mosi_o, latch_o, adc_start_o, busy_o, overrun_o;

  always #2 clk = ~clk;

  dds_word_loader #(.WORD_W(W), .SCLK_HALF(HALF)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick_i), .adc_done_i(adc_done_i),
    .word_i(word_i), .word_vld_i(word_vld_i), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .latch_o(latch_o), .adc_start_o(adc_start_o), .busy_o(busy_o),
    .overrun_o(overrun_o)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // serial-line monitor, sampled at falling clock edges
  logic [W-1:0] rx = '0;
  int  nbits = 0, idle_viol = 0, mosi_viol = 0, phase_bad = 0, hi_len = 0;
  logic p_sclk = 1'b0, p_mosi = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (sclk_o && !p_sclk) begin
        rx = {rx[W-2:0], mosi_o};
        nbits++;
      end
      if (sclk_o && p_sclk && mosi_o != p_mosi) mosi_viol++;
      if (sclk_o && !busy_o) idle_viol++;
      if (sclk_o) hi_len++;
      else if (p_sclk) begin
        if (hi_len != HALF) phase_bad++;
        hi_len = 0;
      end
    end
    p_sclk = sclk_o;
    p_mosi = mosi_o;
  end

  // tick sampled while idle/holding: commit and start conversion
  task automatic do_tick();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
    chk(latch_o == 1'b1, "R5 latch after tick", latch_o, 1);
    chk(adc_start_o == 1'b1, "R6 start pulse", adc_start_o, 1);
    @(negedge clk);
    chk(adc_start_o == 1'b0, "R6 start one cycle", adc_start_o, 0);
  endtask

  // transfer; tick placed to be sampled at edge P0+toff (0 = none)
  task automatic xfer(input logic [W-1:0] w, input int toff);
    int busy_cnt;
    word_i = w; word_vld_i = 1'b1;
    rx = '0; nbits = 0;
    @(negedge clk) adc_done_i = 1'b1;
    @(negedge clk) adc_done_i = 1'b0;
    chk(latch_o == 1'b0, "R4 latch falls", latch_o, 0);
    chk(busy_o == 1'b1, "R4 busy rises", busy_o, 1);
    busy_cnt = 1;
    for (int k = 1; k <= XLEN + 2; k++) begin
      tick_i = (k == toff);
      if (k == 20) word_i = ~w; // R2 upstream change mid-shift
      @(negedge clk);
      tick_i = 1'b0;
      if (busy_o) busy_cnt++;
      if (k == toff && toff <= XLEN) begin
        chk(overrun_o == 1'b1, "R8 overrun pulse", overrun_o, 1);
        chk(latch_o == 1'b0, "R8 latch held", latch_o, 0);
        chk(adc_start_o == 1'b0, "R8 no start", adc_start_o, 0);
      end else if (k == toff) begin
        chk(overrun_o == 1'b0, "R8 no overrun after end", overrun_o, 0);
        chk(latch_o == 1'b1, "R5 latch after end", latch_o, 1);
        chk(adc_start_o == 1'b1, "R6 start after end", adc_start_o, 1);
      end else if (k == toff + 1 && toff != 0) begin
        chk(overrun_o == 1'b0, "R8 overrun one cycle", overrun_o, 0);
      end
    end
    chk(nbits == W, "R1 bit count", nbits, W);
    chk(rx == w, "R1 R2 received word", rx, w);
    chk(busy_cnt == XLEN, "R4 busy length", busy_cnt, XLEN);
    if (toff <= XLEN)
      chk(latch_o == 1'b0, "R4 latch low until tick", latch_o, 0);
    word_vld_i = 1'b0;
  endtask

  logic [W-1:0] pats [4];
  bit done = 1'b0;

  initial begin
    pats[0] = 40'h00_00000000;
    pats[1] = 40'hFF_FFFFFFFF;
    pats[2] = 40'hA5_3C96E10F;
    pats[3] = 40'h5A_C3691EF0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(latch_o == 1'b1, "R10 latch", latch_o, 1);
    chk(sclk_o == 1'b0, "R10 sclk", sclk_o, 0);
    chk(mosi_o == 1'b0, "R10 mosi", mosi_o, 0);
    chk(busy_o == 1'b0, "R10 busy", busy_o, 0);
    chk(adc_start_o == 1'b0, "R10 start", adc_start_o, 0);
    chk(overrun_o == 1'b0, "R10 overrun", overrun_o, 0);
    @(negedge clk) rst = 1'b0;

    // R7: completion with nothing pending is ignored
    word_vld_i = 1'b1; word_i = pats[2];
    @(negedge clk) adc_done_i = 1'b1;
    @(negedge clk) adc_done_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(busy_o == 1'b0 && nbits == 0, "R7 ignored idle", busy_o, 0);

    // R1 R3 sweep: walking one plus patterns
    for (int i = 0; i < W; i++) begin
      do_tick();
      xfer(W'(1) << i, 0);
    end
    for (int i = 0; i < 4; i++) begin
      do_tick();
      xfer(pats[i], 0);
    end

    // R7: completion in hold state ignored, latch stays low
    word_vld_i = 1'b1; nbits = 0;
    @(negedge clk) adc_done_i = 1'b1;
    @(negedge clk) adc_done_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(busy_o == 1'b0 && nbits == 0, "R7 ignored hold", nbits, 0);
    chk(latch_o == 1'b0, "R7 latch untouched in hold", latch_o, 0);

    // R7: completion without valid word
    do_tick();
    word_vld_i = 1'b0;
    @(negedge clk) adc_done_i = 1'b1;
    @(negedge clk) adc_done_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(busy_o == 1'b0 && nbits == 0, "R7 no transfer invalid", nbits, 0);
    chk(latch_o == 1'b1, "R7 latch stays high", latch_o, 1);

    // R9: tick and completion together while pending
    do_tick();
    word_vld_i = 1'b1;
    @(negedge clk) begin tick_i = 1'b1; adc_done_i = 1'b1; end
    @(negedge clk) begin tick_i = 1'b0; adc_done_i = 1'b0; end
    chk(adc_start_o == 1'b1, "R9 start wins", adc_start_o, 1);
    chk(busy_o == 1'b0 && latch_o == 1'b1, "R9 no transfer", busy_o, 0);
    xfer(pats[2], 0);

    // R8: tick at every offset through the shift and just past it
    for (int off = 1; off <= XLEN + 1; off++) begin
      do_tick();
      xfer(pats[off % 4] ^ W'(off), off);
    end

    chk(idle_viol == 0, "R3 sclk idle low", idle_viol, 0);
    chk(mosi_viol == 0, "R3 mosi stable high", mosi_viol, 0);
    chk(phase_bad == 0, "R3 high phase length", phase_bad, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule